// File: doc/BRIEF.md
# E3 Receive Alarm Interrupt Unit

This unit sits beside an E3 receive framer. It turns the framer's alarm and error indications into maskable interrupts. It takes three event sources. The first is the far-end receive failure level, which raises a change event whenever it toggles in either direction. The second is the BIP-4 nibble error pulse, which counts only while BIP-4 checking is enabled by the `bip_proc_en_i` input. The third is the framing error pulse. Each event latches a status bit when its enable bit is set. An active-low interrupt request line stays low while any latched status bit is also enabled.

A synchronous byte-wide register port reaches three registers:

- a configuration/state register at 0x11, which carries the live alarm levels and one writable loss-of-frame algorithm select bit;
- an enable register at 0x13;
- a status register at 0x15, which clears itself when read.

A read asserted in cycle t returns its data on `rdata_o` after the clock edge that ends cycle t. In all other cycles `rdata_o` is 0.

Top module: `e3_rx_alarm_irq`

## Requirements
- R1: After reset the enable register, the status register and the algorithm select bit are 0. `irq_no` is 1 and `rdata_o` is 0.
- R2: The enable register at address 0x13 stores write bits 3 (FERF change), 2 (BIP-4 error) and 1 (framing error). Bits 7..4 and bit 0 read as 0 and ignore writes.
- R3: A read of address 0x11 returns the following fields. Bit 7 is the writable algorithm select, which also drives `lof_algo_o`. Bit 6 is lof_i, bit 5 is oof_i, bit 4 is los_i, bit 3 is ais_i and bit 0 is ferf_i. Bits 2 and 1 read as 0. Writes to bits 6..0 are ignored.
- R4: A change of ferf_i in either direction sets status bit 3 when enable bit 3 is 1.
- R5: A bip_err_i pulse sets status bit 2 only when enable bit 2 is 1 and bip_proc_en_i is 1.
- R6: A frm_err_i pulse sets status bit 1 when enable bit 1 is 1.
- R7: An event whose enable bit is 0 leaves its status bit unchanged.
- R8: A read of address 0x15 returns the status register, with bits 7..4 and bit 0 reading 0, and then clears every status bit.
- R9: An event that arrives in the same cycle as a status read leaves its status bit set after the read. The read itself returns the value held before that event.
- R10: `irq_no` is 0 exactly when some status bit and its enable bit are both 1. Otherwise it is 1.
- R11: A read of any other address returns 0. A write to any address other than 0x11 and 0x13 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ferf_i | input | 1 | Far-end receive failure level from framer |
| ais_i | input | 1 | Alarm indication signal level |
| los_i | input | 1 | Loss of signal level |
| oof_i | input | 1 | Out of frame level |
| lof_i | input | 1 | Loss of frame level |
| bip_err_i | input | 1 | BIP-4 nibble error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| bip_proc_en_i | input | 1 | BIP-4 checking enabled |
| cs_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the read |
| lof_algo_o | output | 1 | Loss-of-frame algorithm select |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench aims at FERF clearing as well as declaring. A design that detected only a rising edge would miss the 1-to-0 interrupt. It also aims at BIP-4 pulses sent with checking turned off, which a design without the gate would latch. Events are placed in the very cycle of a status read. A design that let the clear win would lose them and drop `irq_no` back to 1. Writes of all ones go to the enable and configuration registers, and writes go to the status address. These would expose stray stored bits, or read-only fields that can be written.

// File: rtl/e3_irq_pkg.sv
package e3_irq_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned FERF_BIT = 3;
  localparam int unsigned BIP_BIT  = 2;
  localparam int unsigned FRM_BIT  = 1;
  localparam logic [DW-1:0] IRQ_MASK = (DW'(1) << FERF_BIT) | (DW'(1) << BIP_BIT) | (DW'(1) << FRM_BIT);
  localparam int unsigned ALGO_BIT = 7;
endpackage

// File: rtl/e3_irq_event.sv
module e3_irq_event
  import e3_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ferf_i,
  input  logic          bip_err_i,
  input  logic          frm_err_i,
  input  logic          bip_proc_en_i,
  output logic [DW-1:0] ev_o
);
  logic ferf_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ferf_q <= 1'b0;
    else         ferf_q <= ferf_i;

  always_comb begin
    ev_o           = '0;
    ev_o[FERF_BIT] = ferf_i ^ ferf_q;          // both declare and clear
    ev_o[BIP_BIT]  = bip_err_i & bip_proc_en_i;
    ev_o[FRM_BIT]  = frm_err_i;
  end

  AST_BIP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bip_proc_en_i |-> !ev_o[BIP_BIT]); // R5
  AST_FERF_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferf_i != $past(ferf_i)) |-> ev_o[FERF_BIT]); // R4
endmodule

// File: rtl/e3_irq_cfg.sv
module e3_irq_cfg
  import e3_irq_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] CFG_ADDR = 8'h11,
  parameter logic [AW-1:0] IEN_ADDR = 8'h13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ien_o,
  output logic          algo_o
);
  logic [DW-1:0] ien_q;
  logic          algo_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ien_q  <= '0;
      algo_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == IEN_ADDR) ien_q  <= wdata_i & IRQ_MASK;
      if (addr_i == CFG_ADDR) algo_q <= wdata_i[ALGO_BIT];
    end

  assign ien_o  = ien_q;
  assign algo_o = algo_q;

  AST_IEN_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == IEN_ADDR) |=> ((ien_q & ~IRQ_MASK) == '0)); // R2
  AST_ALGO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == CFG_ADDR) |=> $stable(algo_q)); // R11
endmodule

// File: rtl/e3_irq_status.sv
module e3_irq_status
  import e3_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ev_i,
  input  logic [DW-1:0] ien_i,
  input  logic          rd_clr_i,
  output logic [DW-1:0] sts_o,
  output logic          irq_no
);
  logic [DW-1:0] sts_q, set;

  assign set = ev_i & ien_i & IRQ_MASK;

  // a set in the read cycle outlives the clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (rd_clr_i ? '0 : sts_q) | set;

  assign sts_o  = sts_q;
  assign irq_no = ~|(sts_q & ien_i);

  AST_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && set == '0) |=> (sts_q == '0)); // R8
  AST_EVENT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set != '0) |=> ((sts_q & $past(set)) == $past(set))); // R9
  AST_SET_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q & ~$past(sts_q) & ~$past(ien_i)) == '0)); // R7
endmodule

// File: rtl/e3_rx_alarm_irq.sv
module e3_rx_alarm_irq
  import e3_irq_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] CFG_ADDR = 8'h11,
  parameter logic [AW-1:0] IEN_ADDR = 8'h13,
  parameter logic [AW-1:0] STS_ADDR = 8'h15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ferf_i,
  input  logic          ais_i,
  input  logic          los_i,
  input  logic          oof_i,
  input  logic          lof_i,
  input  logic          bip_err_i,
  input  logic          frm_err_i,
  input  logic          bip_proc_en_i,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          lof_algo_o,
  output logic          irq_no
);
  logic [DW-1:0] ev, ien, sts, rdata_q;
  logic          rd, wr, algo;

  assign rd = cs_i & ~we_i;
  assign wr = cs_i &  we_i;

  e3_irq_event u_event (
    .clk_i, .rst_ni, .ferf_i, .bip_err_i, .frm_err_i, .bip_proc_en_i,
    .ev_o (ev)
  );

  e3_irq_cfg #(.AW(AW), .CFG_ADDR(CFG_ADDR), .IEN_ADDR(IEN_ADDR)) u_cfg (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i, .wdata_i,
    .ien_o(ien), .algo_o(algo)
  );

  e3_irq_status u_status (
    .clk_i, .rst_ni, .ev_i(ev), .ien_i(ien),
    .rd_clr_i(rd && addr_i == STS_ADDR),
    .sts_o(sts), .irq_no
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdata_q <= '0;
    else if (rd) begin
      unique case (addr_i)
        CFG_ADDR: rdata_q <= {algo, lof_i, oof_i, los_i, ais_i, 2'b00, ferf_i};
        IEN_ADDR: rdata_q <= ien;
        STS_ADDR: rdata_q <= sts;
        default:  rdata_q <= '0;
      endcase
    end else rdata_q <= '0;

  assign rdata_o    = rdata_q;
  assign lof_algo_o = algo;

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> (rdata_o == '0)); // R11
  AST_IRQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !rd && !wr) |=> !irq_no); // R10
endmodule

// File: tb/e3_rx_alarm_irq_bench.sv
module e3_rx_alarm_irq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ferf = 0, ais = 0, los = 0, oof = 0, lof = 0, bip = 0, frm = 0, proc = 0;
  logic cs = 0, we = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic algo_o, irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  e3_rx_alarm_irq u_e3_rx_alarm_irq (
    .clk_i(clk), .rst_ni(rst_n), .ferf_i(ferf), .ais_i(ais), .los_i(los),
    .oof_i(oof), .lof_i(lof), .bip_err_i(bip), .frm_err_i(frm),
    .bip_proc_en_i(proc), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .lof_algo_o(algo_o), .irq_no(irq_n)
  );

  // reference model
  logic [7:0] m_sts, m_ien, m_rd;
  logic m_algo, m_ferf_q;

  function automatic logic [7:0] ev_vec(logic f, logic fq, logic b, logic p, logic r);
    return {4'b0, f ^ fq, b & p, r, 1'b0};
  endfunction

  function automatic logic [7:0] rd_val(logic [7:0] a, logic [7:0] ien, logic [7:0] sts, logic al);
    case (a)
      8'h11: return {al, lof, oof, los, ais, 2'b00, ferf};
      8'h13: return ien;
      8'h15: return sts;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_sts <= 0; m_ien <= 0; m_rd <= 0; m_algo <= 0; m_ferf_q <= 0;
    end else begin
      logic [7:0] set;
      set = ev_vec(ferf, m_ferf_q, bip, proc, frm) & m_ien;
      m_rd <= (cs && !we) ? rd_val(addr, m_ien, m_sts, m_algo) : 8'h00;
      m_sts <= (((cs && !we && addr == 8'h15) ? 8'h00 : m_sts) | set);
      if (cs && we && addr == 8'h13) m_ien <= wdata & 8'h0E;
      if (cs && we && addr == 8'h11) m_algo <= wdata[7];
      m_ferf_q <= ferf;
    end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // drive at negedge, run one edge, check at next negedge
  task automatic step(logic f, logic b, logic r, logic p, logic c, logic w,
                      logic [7:0] a, logic [7:0] d, string tag);
    ferf = f; bip = b; frm = r; proc = p; cs = c; we = w; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    chk(tag, rdata, m_rd);
    chk("R10 irq", {7'b0, irq_n}, {7'b0, ~|(m_sts & m_ien)});
    chk("R3 algo", {7'b0, algo_o}, {7'b0, m_algo});
  endtask

  task automatic rd(logic [7:0] a, string tag);
    step(ferf, 0, 0, proc, 1, 0, a, 0, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
    step(ferf, 0, 0, proc, 1, 1, a, d, tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 irq reset", {7'b0, irq_n}, 8'h01);
    chk("R1 rdata reset", rdata, 8'h00);
    rst_n = 1;
    rd(8'h13, "R1 ien reset");   chk("R1 ien=0", rdata, 8'h00);
    rd(8'h15, "R1 sts reset");   chk("R1 sts=0", rdata, 8'h00);
    rd(8'h11, "R1 cfg reset");   chk("R1 algo=0", {7'b0, rdata[7]}, 8'h00);
    wr(8'h13, 8'hFF, "R2 write");
    rd(8'h13, "R2 ien read");    chk("R2 ien masked", rdata, 8'h0E);
    wr(8'h11, 8'hFF, "R3 write");
    ais = 1; lof = 1;
    rd(8'h11, "R3 cfg read");    chk("R3 cfg fields", rdata, 8'hC8);
    ais = 0; lof = 0;
    step(1, 0, 0, 0, 0, 0, 0, 0, "R4 declare");
    chk("R10 irq low after FERF", {7'b0, irq_n}, 8'h00);
    rd(8'h15, "R4 sts");         chk("R4 declare bit", rdata, 8'h08);
    rd(8'h15, "R8 cleared");     chk("R8 cleared", rdata, 8'h00);
    step(0, 0, 0, 0, 0, 0, 0, 0, "R4 clear");
    rd(8'h15, "R4 sts clr");     chk("R4 clear bit", rdata, 8'h08);
    step(0, 1, 0, 0, 0, 0, 0, 0, "R5 bip off");
    rd(8'h15, "R5 sts off");     chk("R5 gated", rdata, 8'h00);
    step(0, 1, 0, 1, 0, 0, 0, 0, "R5 bip on");
    rd(8'h15, "R5 sts on");      chk("R5 set", rdata, 8'h04);
    step(0, 0, 1, 1, 0, 0, 0, 0, "R6 frm");
    rd(8'h15, "R6 sts");         chk("R6 set", rdata, 8'h02);
    wr(8'h13, 8'h00, "R7 disable");
    step(1, 1, 1, 1, 0, 0, 0, 0, "R7 events");
    chk("R7 irq high", {7'b0, irq_n}, 8'h01);
    rd(8'h15, "R7 sts");         chk("R7 none set", rdata, 8'h00);
    wr(8'h13, 8'h02, "R9 enable");
    step(1, 0, 1, 1, 1, 0, 8'h15, 0, "R9 read+event");
    chk("R9 old value", rdata, 8'h00);
    chk("R9 irq kept", {7'b0, irq_n}, 8'h00);
    rd(8'h15, "R9 sts");         chk("R9 kept", rdata, 8'h02);
    wr(8'h15, 8'hFF, "R11 write sts");
    wr(8'h40, 8'hFF, "R11 write other");
    rd(8'h13, "R11 ien");        chk("R11 ien unchanged", rdata, 8'h02);
    rd(8'h15, "R11 sts");        chk("R11 sts unchanged", rdata, 8'h00);
    rd(8'h20, "R11 unmapped");   chk("R11 unmapped", rdata, 8'h00);
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] op;
      logic [7:0] a;
      op = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 4))
        0: a = 8'h11; 1: a = 8'h13; 2: a = 8'h15; 3: a = 8'h15;
        default: a = 8'($urandom);
      endcase
      ais = 1'($urandom); los = 1'($urandom); oof = 1'($urandom); lof = 1'($urandom);
      step(($urandom_range(0, 7) == 0) ? ~ferf : ferf, 1'($urandom), 1'($urandom),
           1'($urandom), op < 5, op == 4, a, 8'($urandom),
           (a == 8'h15) ? "R8 rnd" : (a == 8'h13) ? "R2 rnd" : (a == 8'h11) ? "R3 rnd" : "R11 rnd");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule